// File: doc/BRIEF.md
# Partial Reconfiguration Handshake Sequencer

This block runs the host side of one partial-reconfiguration session against a configuration controller. On a start command it checks the raw status inputs before doing anything. These are the mode-select bits, the nCONFIG and nSTATUS pin levels, and whether a partial session (16-bit width) was asked for. If every check passes, it walks a fixed handshake. It selects the device, opens the configuration clock/data gate and takes over the configuration pins. It then asks an external burst counter for dummy clocks on both sides of raising pr_request.

After pr_ready is seen, it hands the data phase to an external streamer. It then waits for pr_done. In every case it releases the controller in a fixed order and ends with a health check of the status inputs. Each poll of a status input is bounded, and pr_error aborts it.

The outcome is held on a 2-bit result code and the block shows `busy` while a session runs. A separate output decodes the live status inputs into a coarse state report.

Top module: `prseq_top`

## Requirements
- R1: Out of reset the outputs are idle: chipSelN=1, prRequest=0, cfgGateEn=0, overrideEn=0, burstClear=0, burstLoad=0, streamEn=0, busy=0, and result=00. The result codes are 00 ok, 01 error, 10 timeout and 11 rejected.
- R2: A start is rejected (result=11, busy stays 0, no output moves, no burst is issued) if any of the following holds: modeSel is other than 000 or 001, nConfigPin is low, nStatusPin is low, or fullCfg is high (only a 16-bit partial session is accepted).
- R3: On an accepted start, chipSelN goes low with prRequest low, then cfgGateEn rises, then overrideEn rises, and then a burst of 256 clocks is loaded.
- R4: After that burst completes, prRequest rises and a burst of 2047 clocks is loaded. streamEn is never high before that second burst has completed.
- R5: Each burst is a burstClear pulse, then a burstLoad pulse with burstCount valid, then a wait for burstDone, then a second burstClear pulse. A session therefore shows exactly twice as many burstClear pulses as burstLoad pulses.
- R6: The wait for prReady samples at most 10 cycles. prError during the wait gives result 01, and 10 samples without prReady give result 10. In both cases teardown follows and streamEn never rises.
- R7: Once prReady is seen, streamEn stays high until streamDone. prDone is then polled with the same error and 10-sample timeout rules.
- R8: Teardown runs after every accepted session, whatever the outcome, in this order: prRequest falls, a 256-clock burst is loaded, cfgGateEn falls, chipSelN rises, and overrideEn falls.
- R9: If no earlier failure occurred, the result is 00 only when userMode, confDone and nStatusPin are all high after teardown. Otherwise the result is 10. An earlier error or timeout code is kept.
- R10: busy is high from the cycle after an accepted start until the session ends. A start seen while busy is ignored and does not alter the session or its result.
- R11: stateReport decodes the live status inputs by priority: userMode gives 1 (operating), else prReady gives 2 (writing), else crcError gives 3 (completed with error), else nStatusPin low gives 4 (reset), else 0 (unknown).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startReq | input | 1 | Start command, sampled while idle |
| fullCfg | input | 1 | High requests a full configuration (rejected) |
| modeSel | input | 3 | Mode-select status bits |
| nConfigPin | input | 1 | nCONFIG pin level |
| nStatusPin | input | 1 | nSTATUS pin level |
| prReady | input | 1 | Controller ready for partial data |
| prDone | input | 1 | Controller finished partial data |
| prError | input | 1 | Controller reports a partial-reconfiguration error |
| userMode | input | 1 | Device in user mode |
| confDone | input | 1 | CONF_DONE pin level |
| crcError | input | 1 | CRC error status |
| streamDone | input | 1 | External streamer has sent all data |
| burstDone | input | 1 | Sticky done flag of the burst counter |
| chipSelN | output | 1 | Active-low chip select |
| prRequest | output | 1 | Partial-reconfiguration request |
| cfgGateEn | output | 1 | Configuration clock/data gate enable |
| overrideEn | output | 1 | Data/clock/select/request override enable |
| burstClear | output | 1 | One-cycle clear of the burst done flag |
| burstLoad | output | 1 | One-cycle load of burstCount into the burst counter |
| burstCount | output | 12 | Burst length in clocks |
| streamEn | output | 1 | Grants the data phase to the streamer |
| busy | output | 1 | Session in progress |
| result | output | 2 | Outcome code of the last start |
| stateReport | output | 3 | Priority-decoded status |

## Verification
A sequencer in the wrong state shows at the ports within a cycle or two. It may select the device or open the gate out of order, or load a burst with prRequest at the wrong level. It may also give the stream grant before the long burst has finished, or leave a pin owned after busy falls. The bench logs the cycle of every output edge and of every burst load in each session, so a reordered or skipped step stands out as a wrong order or a wrong load count. A broken poll bound or a lost failure code instead shows at the end of the session, as a wrong result.

// File: rtl/prseq_pkg.sv
package prseq_pkg;

  typedef enum logic [1:0] {
    RES_OK  = 2'b00,
    RES_ERR = 2'b01,
    RES_TMO = 2'b10,
    RES_REJ = 2'b11
  } resCode_e;

  typedef enum logic [2:0] {
    RPT_UNKNOWN   = 3'd0,
    RPT_OPERATING = 3'd1,
    RPT_WRITING   = 3'd2,
    RPT_DONE_ERR  = 3'd3,
    RPT_RESET     = 3'd4
  } report_e;

  typedef enum logic [4:0] {
    ST_IDLE,
    ST_SEL,
    ST_GATE,
    ST_OVR,
    ST_REQ,
    ST_RDY,
    ST_STREAM,
    ST_DONE,
    ST_TD_REQ,
    ST_TD_GATE,
    ST_TD_SEL,
    ST_TD_OVR,
    ST_CHECK,
    ST_B_CLR1,
    ST_B_LOAD,
    ST_B_WAIT,
    ST_B_CLR2
  } seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic     setBusy;
    logic     clrBusy;
    logic     selChip;
    logic     relChip;
    logic     reqOn;
    logic     reqOff;
    logic     gateOn;
    logic     gateOff;
    logic     ovrOn;
    logic     ovrOff;
    logic     burstClr;
    logic     burstLd;
    logic     burstLong;
    logic     pollRun;
    logic     stream;
    logic     resWr;
    resCode_e resVal;
  } seqStrobe_t;

endpackage

// File: rtl/prseq_report.sv
module prseq_report
  import prseq_pkg::*;
(
  input  logic    userMode,
  input  logic    prReady,
  input  logic    crcError,
  input  logic    nStatusPin,
  output report_e report
);

  always_comb begin
    if (userMode)        report = RPT_OPERATING;
    else if (prReady)    report = RPT_WRITING;
    else if (crcError)   report = RPT_DONE_ERR;
    else if (!nStatusPin) report = RPT_RESET;
    else                 report = RPT_UNKNOWN;
  end

  always_comb begin
    assert (!(userMode && report != RPT_OPERATING))
      else $error("p_usermode_wins_r11");
  end

endmodule

// File: rtl/prseq_ctrl.sv
module prseq_ctrl
  import prseq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic       fullCfg,
  input  logic [2:0] modeSel,
  input  logic       nConfigPin,
  input  logic       nStatusPin,
  input  logic       prReady,
  input  logic       prDone,
  input  logic       prError,
  input  logic       userMode,
  input  logic       confDone,
  input  logic       streamDone,
  input  logic       burstDone,
  input  logic       pollExpired,
  input  resCode_e   curResult,
  output seqStrobe_t stb
);

  seqState_e state, nextState, retQ, nextRet;
  logic      longQ, nextLong;
  logic      entryOk, healthy;

  assign entryOk = !fullCfg && (modeSel[2:1] == 2'b00) && nConfigPin && nStatusPin;
  assign healthy = userMode && confDone && nStatusPin;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      retQ  <= ST_IDLE;
      longQ <= 1'b0;
    end else begin
      state <= nextState;
      retQ  <= nextRet;
      longQ <= nextLong;
    end
  end

  always_comb begin
    stb       = '0;
    stb.resVal = RES_OK;
    nextState = state;
    nextRet   = retQ;
    nextLong  = longQ;
    case (state)
      ST_IDLE: begin
        if (startReq) begin
          stb.resWr = 1'b1;
          if (entryOk) begin
            stb.setBusy = 1'b1;
            stb.resVal  = RES_OK;
            nextState   = ST_SEL;
          end else begin
            stb.resVal = RES_REJ;
          end
        end
      end
      ST_SEL:  begin stb.selChip = 1'b1; nextState = ST_GATE; end
      ST_GATE: begin stb.gateOn  = 1'b1; nextState = ST_OVR;  end
      ST_OVR: begin
        stb.ovrOn = 1'b1;
        nextLong  = 1'b0;
        nextRet   = ST_REQ;
        nextState = ST_B_CLR1;
      end
      ST_REQ: begin
        stb.reqOn = 1'b1;
        nextLong  = 1'b1;
        nextRet   = ST_RDY;
        nextState = ST_B_CLR1;
      end
      ST_RDY: begin
        stb.pollRun = 1'b1;
        if (prError) begin
          stb.resWr = 1'b1; stb.resVal = RES_ERR; nextState = ST_TD_REQ;
        end else if (prReady) begin
          nextState = ST_STREAM;
        end else if (pollExpired) begin
          stb.resWr = 1'b1; stb.resVal = RES_TMO; nextState = ST_TD_REQ;
        end
      end
      ST_STREAM: begin
        stb.stream = 1'b1;
        if (streamDone) nextState = ST_DONE;
      end
      ST_DONE: begin
        stb.pollRun = 1'b1;
        if (prError) begin
          stb.resWr = 1'b1; stb.resVal = RES_ERR; nextState = ST_TD_REQ;
        end else if (prDone) begin
          nextState = ST_TD_REQ;
        end else if (pollExpired) begin
          stb.resWr = 1'b1; stb.resVal = RES_TMO; nextState = ST_TD_REQ;
        end
      end
      ST_TD_REQ: begin
        stb.reqOff = 1'b1;
        nextLong   = 1'b0;
        nextRet    = ST_TD_GATE;
        nextState  = ST_B_CLR1;
      end
      ST_TD_GATE: begin stb.gateOff = 1'b1; nextState = ST_TD_SEL; end
      ST_TD_SEL:  begin stb.relChip = 1'b1; nextState = ST_TD_OVR; end
      ST_TD_OVR:  begin stb.ovrOff  = 1'b1; nextState = ST_CHECK;  end
      ST_CHECK: begin
        stb.clrBusy = 1'b1;
        if (curResult == RES_OK) begin
          stb.resWr  = 1'b1;
          stb.resVal = healthy ? RES_OK : RES_TMO;
        end
        nextState = ST_IDLE;
      end
      ST_B_CLR1: begin stb.burstClr = 1'b1; nextState = ST_B_LOAD; end
      ST_B_LOAD: begin
        stb.burstLd   = 1'b1;
        stb.burstLong = longQ;
        nextState     = ST_B_WAIT;
      end
      ST_B_WAIT: if (burstDone) nextState = ST_B_CLR2;
      ST_B_CLR2: begin stb.burstClr = 1'b1; nextState = retQ; end
      default:   nextState = ST_IDLE;
    endcase
  end

  // a refused start leaves the sequencer idle
  p_reject_stays_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && startReq && !entryOk) |=> (state == ST_IDLE));

  // a failed poll never leads to the streaming phase
  p_no_stream_after_fail_r6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RDY && prError) |=> (state != ST_STREAM));

endmodule

// File: rtl/prseq_dp.sv
module prseq_dp
  import prseq_pkg::*;
#(
  parameter int CNT_W       = 12,
  parameter int SHORT_BURST = 256,
  parameter int LONG_BURST  = 2047,
  parameter int POLL_LIMIT  = 10
)(
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       stb,
  output logic             chipSelN,
  output logic             prRequest,
  output logic             cfgGateEn,
  output logic             overrideEn,
  output logic             burstClear,
  output logic             burstLoad,
  output logic [CNT_W-1:0] burstCount,
  output logic             streamEn,
  output logic             busy,
  output resCode_e         result,
  output logic             pollExpired
);

  localparam int POLL_W = $clog2(POLL_LIMIT + 1);
  localparam logic [CNT_W-1:0] SHORT_VAL = CNT_W'(SHORT_BURST);
  localparam logic [CNT_W-1:0] LONG_VAL  = CNT_W'(LONG_BURST);
  localparam logic [POLL_W-1:0] POLL_LAST = POLL_W'(POLL_LIMIT - 1);

  logic [POLL_W-1:0] pollCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chipSelN   <= 1'b1;
      prRequest  <= 1'b0;
      cfgGateEn  <= 1'b0;
      overrideEn <= 1'b0;
      busy       <= 1'b0;
      result     <= RES_OK;
    end else begin
      if (stb.selChip) chipSelN <= 1'b0;
      else if (stb.relChip) chipSelN <= 1'b1;
      if (stb.reqOn) prRequest <= 1'b1;
      else if (stb.reqOff) prRequest <= 1'b0;
      if (stb.gateOn) cfgGateEn <= 1'b1;
      else if (stb.gateOff) cfgGateEn <= 1'b0;
      if (stb.ovrOn) overrideEn <= 1'b1;
      else if (stb.ovrOff) overrideEn <= 1'b0;
      if (stb.setBusy) busy <= 1'b1;
      else if (stb.clrBusy) busy <= 1'b0;
      if (stb.resWr) result <= stb.resVal;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      burstClear <= 1'b0;
      burstLoad  <= 1'b0;
      burstCount <= '0;
    end else begin
      burstClear <= stb.burstClr;
      burstLoad  <= stb.burstLd;
      if (stb.burstLd) burstCount <= stb.burstLong ? LONG_VAL : SHORT_VAL;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            pollCnt <= '0;
    else if (!stb.pollRun) pollCnt <= '0;
    else if (!pollExpired) pollCnt <= pollCnt + 1'b1;
  end

  assign pollExpired = (pollCnt == POLL_LAST);
  assign streamEn    = stb.stream;

  p_req_needs_sel_r3: assert property (@(posedge clk) disable iff (!rstN)
    prRequest |-> !chipSelN);

  p_gate_needs_sel_r8: assert property (@(posedge clk) disable iff (!rstN)
    cfgGateEn |-> !chipSelN);

  p_stream_needs_req_r4: assert property (@(posedge clk) disable iff (!rstN)
    streamEn |-> (prRequest && cfgGateEn && overrideEn));

  p_idle_released_r1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (chipSelN && !prRequest && !cfgGateEn && !overrideEn));

  p_load_len_r5: assert property (@(posedge clk) disable iff (!rstN)
    burstLoad |-> (burstCount == SHORT_VAL || burstCount == LONG_VAL));

  p_poll_bound_r6: assert property (@(posedge clk) disable iff (!rstN)
    pollCnt <= POLL_LAST);

endmodule

// File: rtl/prseq_top.sv
module prseq_top
  import prseq_pkg::*;
#(
  parameter int CNT_W       = 12,
  parameter int SHORT_BURST = 256,
  parameter int LONG_BURST  = 2047,
  parameter int POLL_LIMIT  = 10
)(
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic             fullCfg,
  input  logic [2:0]       modeSel,
  input  logic             nConfigPin,
  input  logic             nStatusPin,
  input  logic             prReady,
  input  logic             prDone,
  input  logic             prError,
  input  logic             userMode,
  input  logic             confDone,
  input  logic             crcError,
  input  logic             streamDone,
  input  logic             burstDone,
  output logic             chipSelN,
  output logic             prRequest,
  output logic             cfgGateEn,
  output logic             overrideEn,
  output logic             burstClear,
  output logic             burstLoad,
  output logic [CNT_W-1:0] burstCount,
  output logic             streamEn,
  output logic             busy,
  output logic [1:0]       result,
  output logic [2:0]       stateReport
);

  seqStrobe_t stb;
  resCode_e   resultQ;
  report_e    reportV;
  logic       pollExpired;

  prseq_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .startReq(startReq), .fullCfg(fullCfg),
    .modeSel(modeSel), .nConfigPin(nConfigPin), .nStatusPin(nStatusPin),
    .prReady(prReady), .prDone(prDone), .prError(prError),
    .userMode(userMode), .confDone(confDone), .streamDone(streamDone),
    .burstDone(burstDone), .pollExpired(pollExpired),
    .curResult(resultQ), .stb(stb)
  );

  prseq_dp #(
    .CNT_W(CNT_W), .SHORT_BURST(SHORT_BURST),
    .LONG_BURST(LONG_BURST), .POLL_LIMIT(POLL_LIMIT)
  ) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb),
    .chipSelN(chipSelN), .prRequest(prRequest), .cfgGateEn(cfgGateEn),
    .overrideEn(overrideEn), .burstClear(burstClear), .burstLoad(burstLoad),
    .burstCount(burstCount), .streamEn(streamEn), .busy(busy),
    .result(resultQ), .pollExpired(pollExpired)
  );

  prseq_report report_i (
    .userMode(userMode), .prReady(prReady), .crcError(crcError),
    .nStatusPin(nStatusPin), .report(reportV)
  );

  assign result      = resultQ;
  assign stateReport = reportV;

endmodule

// File: tb/prseq_top_tb_top.sv
`timescale 1ns/1ps
module prseq_top_tb_top;

  logic clk = 0;
  logic rstN = 0;
  logic startReq = 0, fullCfg = 0;
  logic [2:0] modeSel = 3'b001;
  logic nConfigPin = 1, nStatusPin = 1;
  logic prReady = 0, prDone = 0, prError = 0;
  logic userMode = 0, confDone = 0, crcError = 0;
  logic streamDone = 0, burstDone = 0;
  logic chipSelN, prRequest, cfgGateEn, overrideEn;
  logic burstClear, burstLoad, streamEn, busy;
  logic [11:0] burstCount;
  logic [1:0] result;
  logic [2:0] stateReport;

  always #5 clk = ~clk;

  prseq_top dut_i (
    .clk(clk), .rstN(rstN), .startReq(startReq), .fullCfg(fullCfg),
    .modeSel(modeSel), .nConfigPin(nConfigPin), .nStatusPin(nStatusPin),
    .prReady(prReady), .prDone(prDone), .prError(prError),
    .userMode(userMode), .confDone(confDone), .crcError(crcError),
    .streamDone(streamDone), .burstDone(burstDone),
    .chipSelN(chipSelN), .prRequest(prRequest), .cfgGateEn(cfgGateEn),
    .overrideEn(overrideEn), .burstClear(burstClear), .burstLoad(burstLoad),
    .burstCount(burstCount), .streamEn(streamEn), .busy(busy),
    .result(result), .stateReport(stateReport)
  );

  int total = 0, bad = 0;
  bit finished = 0;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---- monitor and burst-counter model, on the falling edge ----
  int cyc = 0, loads = 0, clears = 0, burstLeft = 0;
  int loadCnt[8], loadCyc[8];
  logic loadReq[8], loadSel[8], loadGate[8], loadOvr[8];
  int streamAtLoads = -1, streamCycles = 0;
  int selFallCyc, gateRiseCyc, ovrRiseCyc, reqRiseCyc;
  int reqFallCyc, gateFallCyc, selRiseCyc, ovrFallCyc;
  logic pSel = 1, pReq = 0, pGate = 0, pOvr = 0;
  bit errAfterStream = 0, lateReady = 0;
  int lateReadyAt = 0;

  task automatic clearMon();
    loads = 0; clears = 0; streamAtLoads = -1; streamCycles = 0;
    selFallCyc = -1; gateRiseCyc = -1; ovrRiseCyc = -1; reqRiseCyc = -1;
    reqFallCyc = -1; gateFallCyc = -1; selRiseCyc = -1; ovrFallCyc = -1;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (burstClear) begin clears++; burstDone = 0; end
    if (burstLoad) begin
      if (loads < 8) begin
        loadCnt[loads] = burstCount; loadCyc[loads] = cyc;
        loadReq[loads] = prRequest; loadSel[loads] = chipSelN;
        loadGate[loads] = cfgGateEn; loadOvr[loads] = overrideEn;
      end
      loads++;
      burstLeft = 4;
    end else if (burstLeft > 0) begin
      burstLeft--;
      if (burstLeft == 0) burstDone = 1;
    end
    if (pSel && !chipSelN) selFallCyc = cyc;
    if (!pSel && chipSelN) selRiseCyc = cyc;
    if (!pReq && prRequest) reqRiseCyc = cyc;
    if (pReq && !prRequest) reqFallCyc = cyc;
    if (!pGate && cfgGateEn) gateRiseCyc = cyc;
    if (pGate && !cfgGateEn) gateFallCyc = cyc;
    if (!pOvr && overrideEn) ovrRiseCyc = cyc;
    if (pOvr && !overrideEn) ovrFallCyc = cyc;
    pSel = chipSelN; pReq = prRequest; pGate = cfgGateEn; pOvr = overrideEn;
    if (streamEn) begin
      if (streamAtLoads < 0) streamAtLoads = loads;
      streamCycles++;
      if (errAfterStream) prError = 1;
    end
    streamDone = streamEn && (streamCycles >= 3);
    if (lateReady && cyc >= lateReadyAt) prReady = 1;
  end

  task automatic pulseStart();
    @(negedge clk); startReq = 1;
    @(negedge clk); startReq = 0;
  endtask

  // run one accepted session and check its sequence and outcome
  task automatic runSession(string name, logic [1:0] expRes, bit expStream, bit pokeStart);
    int n;
    clearMon();
    pulseStart();
    n = 0;
    while (!busy && n < 10) begin @(negedge clk); n++; end
    check({name, " R10 busy rises"}, busy, 1);
    n = 0;
    while (busy && n < 3000) begin
      @(negedge clk); n++;
      if (pokeStart && streamEn) begin
        modeSel = 3'b111; startReq = 1;
        @(negedge clk); startReq = 0; modeSel = 3'b000;
        check({name, " R10 busy held on start"}, busy, 1);
        pokeStart = 0;
      end
    end
    repeat (3) @(negedge clk);
    check({name, " R6 R9 result"}, result, expRes);
    check({name, " R8 three bursts"}, loads, 3);
    check({name, " R5 clears twice loads"}, clears, 2 * loads);
    check({name, " R3 first burst 256"}, loadCnt[0], 256);
    check({name, " R3 setup at first load"},
          {loadSel[0], loadReq[0], loadGate[0], loadOvr[0]}, 4'b0011);
    check({name, " R3 setup order"},
          (selFallCyc < gateRiseCyc) && (gateRiseCyc < ovrRiseCyc) && (ovrRiseCyc < loadCyc[0]), 1);
    check({name, " R4 second burst 2047"}, loadCnt[1], 2047);
    check({name, " R4 req up before long burst"},
          loadReq[1] && (reqRiseCyc > loadCyc[0]) && (reqRiseCyc < loadCyc[1]), 1);
    check({name, " R4 R7 stream grant"}, streamAtLoads, expStream ? 2 : -1);
    check({name, " R8 teardown burst 256"}, loadCnt[2], 256);
    check({name, " R8 teardown order"},
          (reqFallCyc < loadCyc[2]) && !loadReq[2] && (loadCyc[2] < gateFallCyc) &&
          (gateFallCyc < selRiseCyc) && (selRiseCyc < ovrFallCyc), 1);
    check({name, " R8 released"}, {chipSelN, prRequest, cfgGateEn, overrideEn, busy}, 5'b10000);
  endtask

  task automatic setGood();
    fullCfg = 0; modeSel = 3'b001; nConfigPin = 1; nStatusPin = 1;
    prReady = 1; prDone = 1; prError = 0; userMode = 1; confDone = 1;
    errAfterStream = 0; lateReady = 0;
  endtask

  task automatic reject(string name);
    clearMon();
    pulseStart();
    repeat (3) @(negedge clk);
    check({name, " R2 result rejected"}, result, 2'b11);
    check({name, " R2 stays idle"}, {busy, chipSelN, prRequest, cfgGateEn, overrideEn}, 5'b01000);
    check({name, " R2 no burst"}, loads + clears, 0);
    setGood();
  endtask

  task automatic testReset();
    check("R1 idle outputs",
          {chipSelN, prRequest, cfgGateEn, overrideEn, burstClear, burstLoad, streamEn, busy},
          8'b10000000);
    check("R1 result ok", result, 2'b00);
  endtask

  task automatic testReport();
    userMode = 1; prReady = 1; crcError = 1; nStatusPin = 0; #1;
    check("R11 operating", stateReport, 1);
    userMode = 0; #1;
    check("R11 writing", stateReport, 2);
    prReady = 0; #1;
    check("R11 done err", stateReport, 3);
    crcError = 0; #1;
    check("R11 reset", stateReport, 4);
    nStatusPin = 1; #1;
    check("R11 unknown", stateReport, 0);
    setGood();
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    clearMon();
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1;
    @(negedge clk);
    setGood();
    testReset();

    modeSel = 3'b010; reject("mode 010");
    runSession("good", 2'b00, 1, 0);
    nConfigPin = 0; reject("nconfig low");
    prReady = 0; runSession("ready timeout R6", 2'b10, 0, 0);
    setGood();
    lateReady = 1; prReady = 0; lateReadyAt = cyc + 80;
    runSession("ready late R6", 2'b10, 0, 0);
    setGood();
    nStatusPin = 0; reject("nstatus low");
    prError = 1; prReady = 0; runSession("ready error R6", 2'b01, 0, 0);
    setGood();
    fullCfg = 1; reject("full config");
    errAfterStream = 1; prDone = 0; runSession("done error R7", 2'b01, 1, 0);
    setGood(); prError = 0;
    prDone = 0; runSession("done timeout R7", 2'b10, 1, 0);
    setGood();
    confDone = 0; runSession("final conf_done low R9", 2'b10, 1, 0);
    setGood();
    modeSel = 3'b111; reject("mode 111");
    modeSel = 3'b000; runSession("start while busy R10", 2'b00, 1, 1);
    setGood();
    testReport();

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule